// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects level-sensitive service requests from up to 32 peripheral sources, filters them through a per-source enable mask and an in-service record, and drives one interrupt line to the host processor. The host reaches the block through a small word-wide register port with four locations: configuration, enable mask, in-service, and vector.

To take an interrupt, the host writes the vector location with its lowest bit set. On that clock edge the controller latches the number of the winning source and marks that source as in service. A later read of the vector location returns the number in the upper bits of its low half-word.

When servicing is done, the host writes a one to that source's in-service bit to retire it. Vector 0 is reserved as the error vector. It is returned when an acknowledge finds nothing eligible, which is what happens when software masks a source after its request raised the line but before the acknowledge. Software only has to acknowledge it.

The winner is picked in three steps:
- A configuration field can promote one source above all others.
- Four serial-channel sources, at vectors 27 to 30, can be reordered among themselves through four slot fields.
- Otherwise the higher vector number wins.

Top module: `vpic_top`

## Requirements
- R1: After reset the mask and in-service registers read 0, the vector location reads 0, the interrupt line is low, and the configuration word reads 0x00E40000. That value means the global enable is clear, there is no promotion, the level is 0, and each slot k holds group k.
- R2: Bit v of the mask register (location 1) enables source v when 1. A masked source never raises the line and never becomes the acknowledged vector.
- R3: The interrupt line equals global enable (configuration bit 7) AND "some source is requesting, unmasked and not in service". It is registered, so it follows its inputs one clock later.
- R4: A write to the vector location (3) with bit 0 set latches the winner into bits 15:11 of that location. A write with bit 0 clear leaves the vector location unchanged.
- R5: With no promotion and the identity slot order, the pending source with the highest vector number wins.
- R6: The source named by configuration bits 12:8 beats every other pending source. A value of 0 promotes nothing.
- R7: Configuration bits 23:16 hold four 2-bit slots; slot k sits at bits 17+2k:16+2k. Serial-channel group g is source 27+g and ranks at position 27+k, where k is the highest slot holding g. A group named by no slot keeps position 27+g. Equal ranks go to the higher vector.
- R8: An acknowledge that finds a winner sets that source's in-service bit (location 2). A source in service cannot win or raise the line until the bit is cleared.
- R9: Writing location 2 clears exactly the in-service bits written as 1 and leaves the others unchanged.
- R10: An acknowledge with no eligible source returns vector 0 and changes no in-service bit. Source 0 is never eligible.
- R11: The 3-bit level output always equals configuration bits 15:13.
- R12: Requests are level-sensitive. When a source drops its line it stops being pending, and the interrupt line falls on the next clock if no other source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req_i | input | 32 | Level request per source (bit 0 unused) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register location: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed location (combinational) |
| irq_o | output | 1 | Interrupt request to the host |
| irq_level_o | output | 3 | Interrupt level for the host |

## Verification
A corrupted in-service bit shows at the ports within one acknowledge. A source that should be blocked wins again, or a source that should win is skipped, or the line stays high with nothing left to take. A wrong priority score only shows when two specific sources are pending together, so the stimulus mixes random request patterns and random slot and promotion settings with every acknowledge. Each returned vector is compared with an independent model on the cycle after the acknowledge. The registered interrupt line is checked one clock after each change of requests, mask or in-service state.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    A_CFG   = 2'd0,
    A_MASK  = 2'd1,
    A_INSVC = 2'd2,
    A_VEC   = 2'd3
  } vpic_addr_e;

  localparam int unsigned HP_W      = 5;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned N_SLOTS   = 4;
  localparam int unsigned SLOT_W    = 2;
  localparam int unsigned GIE_BIT   = 7;
  localparam int unsigned HP_LSB    = 8;
  localparam int unsigned LVL_LSB   = 13;
  localparam int unsigned SLOT_LSB  = 16;

  typedef struct packed {
    logic [N_SLOTS-1:0][SLOT_W-1:0] slot;
    logic [LVL_W-1:0]               lvl;
    logic [HP_W-1:0]                hp;
    logic                           gie;
  } vpic_cfg_t;

  function automatic vpic_cfg_t cfg_unpack(input logic [31:0] w);
    vpic_cfg_t c;
    c.gie = w[GIE_BIT];
    c.hp  = w[HP_LSB +: HP_W];
    c.lvl = w[LVL_LSB +: LVL_W];
    for (int k = 0; k < N_SLOTS; k++) begin
      c.slot[k] = w[SLOT_LSB + SLOT_W*k +: SLOT_W];
    end
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input vpic_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[GIE_BIT]           = c.gie;
    w[HP_LSB +: HP_W]    = c.hp;
    w[LVL_LSB +: LVL_W]  = c.lvl;
    for (int k = 0; k < N_SLOTS; k++) begin
      w[SLOT_LSB + SLOT_W*k +: SLOT_W] = c.slot[k];
    end
    return w;
  endfunction

  function automatic vpic_cfg_t cfg_reset();
    vpic_cfg_t c;
    c.gie = 1'b0;
    c.hp  = '0;
    c.lvl = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      c.slot[k] = SLOT_W'(k);
    end
    return c;
  endfunction

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned VEC_W   = $clog2(N_SRC),
  parameter int unsigned ERR_VEC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              win_valid_i,
  input  logic [VEC_W-1:0]  win_idx_i,
  output logic [31:0]       rdata_o,
  output vpic_cfg_t         cfg_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  insvc_o
);

  localparam int unsigned VEC_LSB = 16 - VEC_W;

  vpic_cfg_t         cfg_q, cfg_d;
  logic [N_SRC-1:0]  mask_q, mask_d;
  logic [N_SRC-1:0]  insvc_q, insvc_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              cfg_en, mask_en, insvc_en, vec_en;
  logic              ack, clr_wr;

  // Decode of the write strobe into per-register enables
  always_comb begin
    ack      = wr_i && (addr_i == A_VEC) && wdata_i[0];
    clr_wr   = wr_i && (addr_i == A_INSVC);
    cfg_en   = wr_i && (addr_i == A_CFG);
    mask_en  = wr_i && (addr_i == A_MASK);
    vec_en   = ack;
    insvc_en = clr_wr || (ack && win_valid_i);
  end

  // Next-state values
  always_comb begin
    cfg_d  = cfg_unpack(wdata_i);
    mask_d = wdata_i[N_SRC-1:0];
    vec_d  = win_valid_i ? win_idx_i : VEC_W'(ERR_VEC);
    if (clr_wr) begin
      insvc_d = insvc_q & ~wdata_i[N_SRC-1:0];
    end else begin
      insvc_d = insvc_q | (N_SRC'(1) << win_idx_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= cfg_reset();
      mask_q  <= '0;
      insvc_q <= '0;
      vec_q   <= VEC_W'(ERR_VEC);
    end else begin
      if (cfg_en)   cfg_q   <= cfg_d;
      if (mask_en)  mask_q  <= mask_d;
      if (insvc_en) insvc_q <= insvc_d;
      if (vec_en)   vec_q   <= vec_d;
    end
  end

  // Read multiplexer
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG:   rdata_o = cfg_pack(cfg_q);
      A_MASK:  rdata_o[N_SRC-1:0] = mask_q;
      A_INSVC: rdata_o[N_SRC-1:0] = insvc_q;
      default: rdata_o[VEC_LSB +: VEC_W] = vec_q;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign mask_o  = mask_q;
  assign insvc_o = insvc_q;

  p_ack_marks_insvc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && win_valid_i) |=> (insvc_q[$past(win_idx_i)] && (vec_q == $past(win_idx_i))));

  p_err_keeps_insvc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !win_valid_i) |=> ($stable(insvc_q) && (vec_q == VEC_W'(ERR_VEC))));

  p_vec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack |=> $stable(vec_q));

  p_w1c_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((insvc_q & $past(wdata_i[N_SRC-1:0])) == '0));

endmodule

// File: rtl/vpic_rank.sv
module vpic_rank
  import vpic_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned VEC_W    = $clog2(N_SRC),
  parameter int unsigned GRP_BASE = 27,
  localparam int unsigned SC_W    = VEC_W + 1
) (
  input  vpic_cfg_t             cfg_i,
  output logic [N_SRC-1:0][SC_W-1:0] score_o
);

  for (genvar v = 0; v < N_SRC; v++) begin : g_src
    logic promo;
    assign promo = (cfg_i.hp == HP_W'(v));

    if ((v >= GRP_BASE) && (v < GRP_BASE + N_SLOTS)) begin : g_grp
      logic [VEC_W-1:0] rank;
      // Highest slot naming this group sets its position
      always_comb begin
        rank = VEC_W'(v);
        for (int k = 0; k < N_SLOTS; k++) begin
          if (cfg_i.slot[k] == SLOT_W'(v - GRP_BASE)) begin
            rank = VEC_W'(GRP_BASE + k);
          end
        end
      end
      assign score_o[v] = {promo, rank};
    end else begin : g_plain
      assign score_o[v] = {promo, VEC_W'(v)};
    end
  end

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned VEC_W = $clog2(N_SRC),
  localparam int unsigned SC_W = VEC_W + 1
) (
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][SC_W-1:0]  score_i,
  output logic                        valid_o,
  output logic [VEC_W-1:0]            idx_o
);

  logic [SC_W-1:0] best;

  // Ascending scan with >= so equal scores resolve to the higher vector
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int v = 0; v < N_SRC; v++) begin
      if (elig_i[v] && (!valid_o || (score_i[v] >= best))) begin
        valid_o = 1'b1;
        idx_o   = VEC_W'(v);
        best    = score_i[v];
      end
    end
  end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned GRP_BASE = 27,
  parameter int unsigned ERR_VEC  = 0,
  localparam int unsigned VEC_W   = $clog2(N_SRC),
  localparam int unsigned SC_W    = VEC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic [2:0]        irq_level_o
);

  logic [1:0]              rst_sync_q;
  logic                    rst_n;
  vpic_cfg_t               cfg;
  logic [N_SRC-1:0]        mask_q, insvc_q, elig;
  logic [N_SRC-1:0][SC_W-1:0] score;
  logic                    win_valid;
  logic [VEC_W-1:0]        win_idx;
  logic                    irq_d, irq_q;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  vpic_regs #(.N_SRC(N_SRC), .VEC_W(VEC_W), .ERR_VEC(ERR_VEC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .rdata_o     (bus_rdata_o),
    .cfg_o       (cfg),
    .mask_o      (mask_q),
    .insvc_o     (insvc_q)
  );

  vpic_rank #(.N_SRC(N_SRC), .VEC_W(VEC_W), .GRP_BASE(GRP_BASE)) u_rank (
    .cfg_i   (cfg),
    .score_o (score)
  );

  always_comb begin
    elig          = src_req_i & mask_q & ~insvc_q;
    elig[ERR_VEC] = 1'b0;
  end

  vpic_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .elig_i  (elig),
    .score_i (score),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  always_comb irq_d = cfg.gie && (|elig);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o       = irq_q;
  assign irq_level_o = cfg.lvl;

  p_gie_gates_line_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg.gie |=> !irq_o);

  p_winner_unmasked_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_valid |-> (mask_q[win_idx] && src_req_i[win_idx] && !insvc_q[win_idx]));

  p_err_never_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_valid |-> (win_idx != VEC_W'(ERR_VEC)));

  p_line_drops_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((src_req_i & mask_q & ~insvc_q) == '0) |=> !irq_o);

endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] req;
  logic        wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  lvl;

  int n_chk;
  int n_fail;

  logic [31:0] m_mask, m_insvc, m_cfg;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  vpic_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_req_i   (req),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .irq_level_o (lvl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input logic gie, input logic [4:0] hp,
                                         input logic [2:0] lv, input logic [7:0] slots);
    return {8'h00, slots, lv, hp, gie, 7'h00};
  endfunction

  // Independent model: highest key wins; key = promotion, rank, vector
  function automatic int model_win(input logic [31:0] rq, input logic [31:0] mk,
                                   input logic [31:0] sv, input logic [31:0] cf);
    int best_v = -1;
    int best_k = -1;
    for (int v = 1; v < 32; v++) begin
      if (rq[v] && mk[v] && !sv[v]) begin
        int rank = v;
        int key;
        if (v >= 27 && v <= 30) begin
          for (int k = 0; k < 4; k++)
            if (cf[16+2*k +: 2] == 2'(v - 27)) rank = 27 + k;
        end
        key = ((cf[12:8] == 5'(v)) ? 100000 : 0) + rank * 100 + v;
        if (key > best_k) begin best_k = key; best_v = v; end
      end
    end
    return best_v;
  endfunction

  function automatic logic model_irq();
    logic [31:0] e;
    e = req & m_mask & ~m_insvc;
    e[0] = 1'b0;
    return m_cfg[7] && (e != 0);
  endfunction

  // Acknowledge, update the model, read and compare the vector
  task automatic ack_and_check(input string tag);
    int w;
    logic [31:0] d;
    w = model_win(req, m_mask, m_insvc, m_cfg);
    bus_write(2'd3, 32'h1);
    if (w >= 0) m_insvc[w] = 1'b1;
    bus_read(2'd3, d);
    check(tag, {27'd0, d[15:11]}, (w < 0) ? 32'd0 : 32'(w));
  endtask

  task automatic set_req(input logic [31:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0;
    req = '0; wr = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    m_mask = '0; m_insvc = '0; m_cfg = 32'h00E4_0000;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(2'd0, d); check("R1 cfg", d, 32'h00E4_0000);
    bus_read(2'd1, d); check("R1 mask", d, 32'd0);
    bus_read(2'd2, d); check("R1 insvc", d, 32'd0);
    bus_read(2'd3, d); check("R1 vec", d, 32'd0);

    // R11 level follows config
    m_cfg = mk_cfg(1'b0, 5'd0, 3'd5, 8'hE4);
    bus_write(2'd0, m_cfg);
    check("R11 level", {29'd0, lvl}, 32'd5);

    // R3 global enable gates the line
    m_mask = 32'h0000_0210;
    bus_write(2'd1, m_mask);
    set_req(32'h0000_0210);
    check("R3 gie off", {31'd0, irq}, 32'd0);
    m_cfg = mk_cfg(1'b1, 5'd0, 3'd5, 8'hE4);
    bus_write(2'd0, m_cfg);
    @(negedge clk);
    check("R3 gie on", {31'd0, irq}, 32'd1);

    // R5 higher vector wins; R8 in-service marks and blocks
    ack_and_check("R5 first ack");
    bus_read(2'd2, d); check("R8 insvc bit9", d, 32'h0000_0200);
    ack_and_check("R8 second ack");
    @(negedge clk);
    check("R8 line low all in service", {31'd0, irq}, 32'd0);
    ack_and_check("R10 empty ack");
    bus_read(2'd2, d); check("R10 insvc unchanged", d, 32'h0000_0210);

    // R9 write-one-to-clear
    bus_write(2'd2, 32'h0000_0200);
    m_insvc[9] = 1'b0;
    bus_read(2'd2, d); check("R9 w1c", d, 32'h0000_0010);

    // R4 write without bit 0 leaves vector alone
    bus_read(2'd3, d);
    bus_write(2'd3, 32'h0000_FFFE);
    begin
      logic [31:0] d2;
      bus_read(2'd3, d2); check("R4 no ack", d2, d);
    end

    // R2 masked source ignored
    bus_write(2'd2, 32'hFFFF_FFFF); m_insvc = '0;
    set_req(32'h0000_1000);
    check("R2 masked no line", {31'd0, irq}, 32'd0);
    ack_and_check("R2 masked not vectored");

    // R6 promotion
    m_mask = 32'hFFFF_FFFE; bus_write(2'd1, m_mask);
    m_cfg = mk_cfg(1'b1, 5'd4, 3'd0, 8'hE4); bus_write(2'd0, m_cfg);
    set_req(32'h0010_0010);
    ack_and_check("R6 promoted");
    bus_write(2'd2, 32'hFFFF_FFFF); m_insvc = '0;

    // R7 group reorder: slot3 holds group 0
    m_cfg = mk_cfg(1'b1, 5'd0, 3'd0, 8'h1B); bus_write(2'd0, m_cfg);
    set_req(32'h4800_0000);
    ack_and_check("R7 group reorder");
    bus_write(2'd2, 32'hFFFF_FFFF); m_insvc = '0;

    // R12 level-sensitive drop
    set_req(32'h0000_0100);
    check("R12 line up", {31'd0, irq}, 32'd1);
    set_req(32'h0000_0000);
    check("R12 line down", {31'd0, irq}, 32'd0);

    // R10 mask race: line high, mask removed before ack
    set_req(32'h0000_0040);
    m_mask = 32'h0; bus_write(2'd1, m_mask);
    ack_and_check("R10 masked race");
    m_mask = 32'hFFFF_FFFE; bus_write(2'd1, m_mask);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 4) == 0) begin
        m_mask = $urandom; bus_write(2'd1, m_mask);
      end
      if (($urandom % 6) == 0) begin
        m_cfg = mk_cfg(($urandom % 8) != 0, 5'($urandom), 3'($urandom), 8'($urandom));
        bus_write(2'd0, m_cfg);
        check("R11 random level", {29'd0, lvl}, {29'd0, m_cfg[15:13]});
      end
      set_req($urandom & $urandom);
      check("R3 random line", {31'd0, irq}, {31'd0, model_irq()});
      ack_and_check("R7 random vector");
      if (($urandom % 2) == 0) begin
        logic [31:0] c;
        c = $urandom;
        bus_write(2'd2, c);
        m_insvc = m_insvc & ~c;
        bus_read(2'd2, d); check("R9 random insvc", d, m_insvc);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule